// File: doc/BRIEF.md
# Line-code frame receiver and checker

This block sits behind word alignment in a serial receive path. Each cycle it may take one frame that is already aligned. The frame holds a data field followed by a 4-bit coding field. The data field is 16 or 20 bits wide, chosen by a mode input, and the first-transmitted bit of the frame is its MSB. The block sorts each frame into one of four kinds: data, control, fill or illegal. It undoes the conditional inversion that the transmitter applied for DC balance. It then presents the user word one cycle later with a data strobe or a control strobe. Fill frames are dropped without a strobe.

Two checks run on the stream. The first is coding-field legality. The second is strict alternation of a FLAG bit across data frames: each data frame must carry the opposite FLAG from the data frame before it, and control and fill frames play no part in this. When a check fails, a registered error pulse is raised in the same cycle as that frame's output. In flag-select mode the alternation check is switched off and FLAG is delivered as one extra user bit. A restart input clears the alternation history so that a higher-level protocol can force the link to lock again.

Top module: `lcr_rx`

## Requirements
- R1: A frame occupies frame_i[23:0] in wide mode and frame_i[19:0] in narrow mode; bits [23:20] are ignored in narrow mode. The coding field is frame_i[3:0] = {C3,C2,C1,C0}. C2C1=01 passes the data field as is, and C2C1=10 outputs its bitwise inverse.
- R2: On a non-fill frame, C3C0=01 is a data frame with FLAG=0, C3C0=10 is a data frame with FLAG=1, and C3C0=11 is a control frame. A data frame asserts data_valid_o and a control frame asserts ctrl_valid_o, with the restored word on data_o.
- R3: A frame with an all-zero data field and coding field 0011 is fill. It gives no strobe and no error.
- R4: A non-fill frame with C2 equal to C1, or with C3C0=00, asserts error_o, gives no strobe and leaves the alternation history unchanged.
- R5: With flag-select off, a data frame whose FLAG equals the FLAG of the previous data frame asserts error_o together with data_valid_o. Control, fill and illegal frames neither update nor break the history.
- R6: The first data frame after reset or restart never raises an alternation error.
- R7: With flag_sel_i high there is no alternation check, and FLAG appears on data_o[16] in narrow mode or on data_o[20] in wide mode. With flag_sel_i low, data_o[20:16] carries only data-field bits (bit 20 is always 0).
- R8: While restart_i is high, the frame presented in that cycle is discarded and the alternation history is cleared.
- R9: All outputs are registered one cycle after the frame. error_o is a single-cycle pulse. In a cycle with no strobe, data_o is zero.
- R10: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Clears checker history, drops the current frame |
| wide_i | input | 1 | 1: 20-bit data field, 0: 16-bit |
| flag_sel_i | input | 1 | 1: FLAG is user data, alternation check off |
| frame_valid_i | input | 1 | frame_i holds a frame this cycle |
| frame_i | input | 24 | Aligned frame, first-transmitted bit at MSB of the active width |
| data_valid_o | output | 1 | data_o holds a data word |
| ctrl_valid_o | output | 1 | data_o holds a control word |
| error_o | output | 1 | Coding or alternation error on this output cycle |
| data_o | output | 21 | Restored word, with FLAG at bit 16 or bit 20 in flag-select mode |

## Verification
The hardest case to reach is an alternation break hidden behind frames that must not count. Examples are two FLAG=1 data frames separated by control and fill frames, or separated by frames that arrive while flag-select is on. The expected result in those cases depends on history that the ports never show. The stimulus table is therefore one continuous stream, with no reset between rows. Control, fill, illegal, flag-select and restart rows are interleaved so that each later data frame's error bit follows only from the last data frame that counted. A directed asynchronous reset in the middle of the run then shows that a repeated FLAG no longer errors.

// File: rtl/lcr_pkg.sv
package lcr_pkg;
  localparam int CF_W = 4;
  localparam int C3_B = 3;
  localparam int C2_B = 2;
  localparam int C1_B = 1;
  localparam int C0_B = 0;
  localparam logic [CF_W-1:0] FILL_CF = 4'b0011;

  typedef enum logic [1:0] {
    FR_FILL = 2'd0,
    FR_DATA = 2'd1,
    FR_CTRL = 2'd2,
    FR_BAD  = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/lcr_decode.sv
module lcr_decode
  import lcr_pkg::*;
#(
  parameter int MAX_DW    = 20,
  parameter int NARROW_DW = 16,
  localparam int FW       = MAX_DW + CF_W
) (
  input  logic [FW-1:0]     frame_i,
  input  logic              wide_i,
  output frame_kind_e       kind_o,
  output logic              flag_o,
  output logic [MAX_DW-1:0] word_o
);
  logic [CF_W-1:0]   cf;
  logic [MAX_DW-1:0] mask, field;
  logic              is_fill;

  always_comb begin
    cf = frame_i[CF_W-1:0];
    for (int b = 0; b < MAX_DW; b++) mask[b] = wide_i || (b < NARROW_DW);
    field   = frame_i[FW-1:CF_W] & mask;
    is_fill = (field == '0) && (cf == FILL_CF);
    word_o  = (field ^ {MAX_DW{cf[C2_B]}}) & mask;
    flag_o  = cf[C3_B];
    if (is_fill)                 kind_o = FR_FILL;
    else if (cf[C2_B] == cf[C1_B]) kind_o = FR_BAD;
    else begin
      unique case ({cf[C3_B], cf[C0_B]})
        2'b01, 2'b10: kind_o = FR_DATA;
        2'b11:        kind_o = FR_CTRL;
        default:      kind_o = FR_BAD;
      endcase
    end
  end
endmodule

// File: rtl/lcr_flag_track.sv
module lcr_flag_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic upd_i,
  input  logic flag_i,
  output logic brk_o
);
  logic have_ref_q, last_q;

  // a repeated flag breaks alternation once a reference exists
  assign brk_o = have_ref_q && (flag_i == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_ref_q <= 1'b0;
      last_q     <= 1'b0;
    end else if (clear_i) begin
      have_ref_q <= 1'b0;
    end else if (upd_i) begin
      have_ref_q <= 1'b1;
      last_q     <= flag_i;
    end
  end
endmodule

// File: rtl/lcr_out_stage.sv
module lcr_out_stage #(
  parameter int W = 21
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dv_d_i,
  input  logic         cv_d_i,
  input  logic         err_d_i,
  input  logic [W-1:0] data_d_i,
  output logic         dv_o,
  output logic         cv_o,
  output logic         err_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_o   <= 1'b0;
      cv_o   <= 1'b0;
      err_o  <= 1'b0;
      data_o <= '0;
    end else begin
      dv_o   <= dv_d_i;
      cv_o   <= cv_d_i;
      err_o  <= err_d_i;
      data_o <= data_d_i;
    end
  end
endmodule

// File: rtl/lcr_rx.sv
module lcr_rx
  import lcr_pkg::*;
#(
  parameter int MAX_DW    = 20,
  parameter int NARROW_DW = 16,
  localparam int FW       = MAX_DW + CF_W,
  localparam int OW       = MAX_DW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          wide_i,
  input  logic          flag_sel_i,
  input  logic          frame_valid_i,
  input  logic [FW-1:0] frame_i,
  output logic          data_valid_o,
  output logic          ctrl_valid_o,
  output logic          error_o,
  output logic [OW-1:0] data_o
);
  frame_kind_e       kind;
  logic              flag, brk, accept, is_data, is_ctrl, upd, err_d;
  logic [MAX_DW-1:0] word;
  logic [OW-1:0]     data_d;

  lcr_decode #(.MAX_DW(MAX_DW), .NARROW_DW(NARROW_DW)) i_decode (
    .frame_i (frame_i),
    .wide_i  (wide_i),
    .kind_o  (kind),
    .flag_o  (flag),
    .word_o  (word)
  );

  always_comb begin
    accept  = frame_valid_i && !restart_i;
    is_data = accept && (kind == FR_DATA);
    is_ctrl = accept && (kind == FR_CTRL);
    upd     = is_data && !flag_sel_i;
    err_d   = accept && ((kind == FR_BAD) || (upd && brk));
    data_d  = '0;
    if (is_data || is_ctrl) data_d[MAX_DW-1:0] = word;
    if (is_data && flag_sel_i) begin
      if (wide_i) data_d[MAX_DW]    = flag;
      else        data_d[NARROW_DW] = flag;
    end
  end

  lcr_flag_track i_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart_i),
    .upd_i   (upd),
    .flag_i  (flag),
    .brk_o   (brk)
  );

  lcr_out_stage #(.W(OW)) i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dv_d_i   (is_data),
    .cv_d_i   (is_ctrl),
    .err_d_i  (err_d),
    .data_d_i (data_d),
    .dv_o     (data_valid_o),
    .cv_o     (ctrl_valid_o),
    .err_o    (error_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/lcr_rx_chk.sv
module lcr_rx_chk
  import lcr_pkg::*;
#(
  parameter int MAX_DW = 20,
  localparam int FW    = MAX_DW + CF_W,
  localparam int OW    = MAX_DW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          restart_i,
  input logic          flag_sel_i,
  input logic          frame_valid_i,
  input logic [FW-1:0] frame_i,
  input logic          data_valid_o,
  input logic          ctrl_valid_o,
  input logic          error_o,
  input logic [OW-1:0] data_o
);
  p_one_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_valid_o, ctrl_valid_o}));

  p_c2c1_equal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_valid_i && !restart_i && (frame_i[C2_B] == frame_i[C1_B]))
    |=> (error_o && !data_valid_o && !ctrl_valid_o));

  p_ctrl_no_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o |-> !error_o);

  p_no_flag_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !$past(flag_sel_i)) |-> !data_o[MAX_DW]);

  p_restart_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!data_valid_o && !ctrl_valid_o && !error_o));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> $past(frame_valid_i && !restart_i));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> (!data_valid_o && !ctrl_valid_o && !error_o && (data_o == '0)));
endmodule

bind lcr_rx lcr_rx_chk #(.MAX_DW(MAX_DW)) i_lcr_rx_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .restart_i     (restart_i),
  .flag_sel_i    (flag_sel_i),
  .frame_valid_i (frame_valid_i),
  .frame_i       (frame_i),
  .data_valid_o  (data_valid_o),
  .ctrl_valid_o  (ctrl_valid_o),
  .error_o       (error_o),
  .data_o        (data_o)
);

// File: tb/test_lcr_rx.sv
module test_lcr_rx;
  localparam time CLK_P = 20ns;
  localparam int  NV    = 22;
  localparam int  VW    = 52;

  // {restart, flag_sel, wide, valid, frame[23:0], exp_dv, exp_cv, exp_err, exp_data[20:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0001, 24'hF12343, 3'b100, 21'h001234}, // R1 upper nibble ignored, R2 data flag0, R6 first
    {4'b0001, 24'h0ABCDA, 3'b100, 21'h00ABCD}, // R2 flag1
    {4'b0001, 24'h05555B, 3'b010, 21'h005555}, // R2 control
    {4'b0001, 24'h000003, 3'b000, 21'h000000}, // R3 fill
    {4'b0001, 24'h0FF005, 3'b100, 21'h0000FF}, // R1 inverted, R5 ok past ctrl/fill
    {4'b0001, 24'h00F0F3, 3'b101, 21'h000F0F}, // R5 repeat flag0
    {4'b0001, 24'h01111C, 3'b100, 21'h00EEEE}, // R1 inverted flag1
    {4'b0001, 24'h012342, 3'b001, 21'h000000}, // R4 C3C0=00
    {4'b0001, 24'h012347, 3'b001, 21'h000000}, // R4 C2==C1
    {4'b0001, 24'h022223, 3'b100, 21'h002222}, // R4 history untouched
    {4'b0011, 24'hABCDEA, 3'b100, 21'h0ABCDE}, // R1 wide
    {4'b0011, 24'h0FFFFD, 3'b010, 21'h0F0000}, // R1 wide inverted control
    {4'b0101, 24'h03333A, 3'b100, 21'h013333}, // R7 flag at bit 16
    {4'b0101, 24'h04444A, 3'b100, 21'h014444}, // R7 repeat flag no error
    {4'b0111, 24'h00000C, 3'b100, 21'h1FFFFF}, // R7 flag at bit 20
    {4'b1001, 24'h07777A, 3'b000, 21'h000000}, // R8 frame dropped
    {4'b0001, 24'h07777A, 3'b100, 21'h007777}, // R6 R8 no error after restart
    {4'b0000, 24'h012342, 3'b000, 21'h000000}, // R9 idle
    {4'b0011, 24'h000003, 3'b000, 21'h000000}, // R3 wide fill
    {4'b0001, 24'h0AAAAB, 3'b010, 21'h00AAAA}, // R5 control between
    {4'b0001, 24'h08888A, 3'b101, 21'h008888}, // R5 repeat flag1 across control/fill
    {4'b0001, 24'h099993, 3'b100, 21'h009999}  // R5 back in step
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        restart_i = 1'b0, wide_i = 1'b0, flag_sel_i = 1'b0, frame_valid_i = 1'b0;
  logic [23:0] frame_i = '0;
  logic        data_valid_o, ctrl_valid_o, error_o;
  logic [20:0] data_o;
  int          n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  lcr_rx i_lcr_rx (
    .clk_i, .rst_ni, .restart_i, .wide_i, .flag_sel_i, .frame_valid_i, .frame_i,
    .data_valid_o, .ctrl_valid_o, .error_o, .data_o
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic dv, input logic cv, input logic er,
                         input logic [20:0] d);
    chk(req, {data_valid_o, ctrl_valid_o, error_o, data_o},
             {dv, cv, er, d});
  endtask

  task automatic drive(input logic rs, input logic fs, input logic wd, input logic vl,
                       input logic [23:0] fr);
    restart_i = rs; flag_sel_i = fs; wide_i = wd; frame_valid_i = vl; frame_i = fr;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    drive(0, 0, 0, 1, 24'h01234A);
    repeat (3) @(negedge clk_i);
    chk_out("R10 reset", 0, 0, 0, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51], VEC[i][50], VEC[i][49], VEC[i][48], VEC[i][47:24]);
      @(negedge clk_i);
      chk_out($sformatf("vec%0d R1..R9", i), VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:0]);
    end
    // R9 error pulse lasts one cycle
    drive(0, 0, 0, 1, 24'h012340);
    @(negedge clk_i);
    chk("R9 err set", {23'd0, error_o}, 24'd1);
    drive(0, 0, 0, 0, '0);
    @(negedge clk_i);
    chk("R9 err pulse", {23'd0, error_o}, 24'd0);
    // R10 R6 async reset clears history
    drive(0, 0, 0, 1, 24'h01111A);
    @(negedge clk_i);
    chk_out("R5 setup", 1, 0, 0, 21'h001111);
    #(CLK_P/4) rst_ni = 1'b0;
    #(CLK_P/4);
    chk_out("R10 async reset", 0, 0, 0, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(0, 0, 0, 1, 24'h02222A);
    @(negedge clk_i);
    chk_out("R6 after reset", 1, 0, 0, 21'h002222);
    drive(0, 0, 0, 1, 24'h03333A);
    @(negedge clk_i);
    chk_out("R5 repeat after reset", 1, 0, 1, 21'h003333);
    drive(0, 0, 0, 0, '0);
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule